// File: doc/BRIEF.md
# Two-Stage Programmable Serial Clock Generator

This block makes the serial clock for a SPI shift engine from the system clock. A prescaler first counts the system clock down by `pre_div + 1`. Each prescaler tick then advances a phase counter that runs from 0 to `lo_cmp` and wraps. Two compare points on that counter set the duty cycle. At `hi_cmp` the clock moves from its idle level to its active level. At `lo_cmp` it returns to idle. For a divider setting N, software programs `lo_cmp = N` and `hi_cmp = floor((N+1)/2 - 1)`. The resulting rate is f_sys / (pre_div+1) / (N+1).

Two single-cycle strobes tell the shift engine when the clock has just changed level. `lead_stb` marks the move away from the idle level and `trail_stb` marks the return to it. The shift engine launches and samples data on these strobes.

A bypass input sends the system clock itself to the output. An idle-level input picks the polarity of the clock. A disable input pins the output pin at its idle level. The sequencing of transactions belongs to the shift engine and is not part of this block.

Top module: `spi_sclk_gen`

## Requirements
- R1: While `rst_n` is low and after reset with `en` low, `sclk` equals `idle_high`, and `lead_stb` and `trail_stb` are 0.
- R2: In divided mode (`bypass`=0, `sclk_off`=0, N = `lo_cmp` >= 1, `hi_cmp` < N), count t as the clock edges at which `en` has been sampled 1 since it rose. After edge t, `sclk` is at its active level (not `idle_high`) exactly when floor(t/(pre_div+1)) mod (N+1) > `hi_cmp`. This gives a period of (pre_div+1)(N+1) cycles.
- R3: In divided mode, `lead_stb` is 1 for exactly the one cycle after the edge at which `sclk` left its idle level. It is never 1 together with `trail_stb`.
- R4: In divided mode, `trail_stb` is 1 for exactly the one cycle after the edge at which `sclk` returned to its idle level.
- R5: With `hi_cmp` = `lo_cmp` = 0, the clock changes level on every prescaler tick. After edge t it is active when floor(t/(pre_div+1)) is odd.
- R6: `idle_high`=1 inverts the clock, so the idle level is high and the active level is low. With `idle_high`=0 the idle level is low.
- R7: At the first clock edge after `en` is seen low, the counters clear, `sclk` goes to idle and both strobes go to 0. When `en` is raised again, the count restarts from zero as in R2.
- R8: With `bypass`=1 and `en`=1, `sclk` equals `clk` XOR `idle_high`, and both strobes are 1 in every cycle. The divider fields have no effect. With `en`=0, `sclk` is at idle.
- R9: `sclk_off`=1 holds `sclk` at `idle_high`. The strobes keep their R2–R5 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Runs the generator; low holds it at idle |
| bypass | input | 1 | Passes the system clock to the output |
| pre_div | input | PRE_W (4) | Prescaler setting; divides by pre_div+1 |
| lo_cmp | input | CNT_W (6) | Count at which the clock returns to idle and the counter wraps (N) |
| hi_cmp | input | CNT_W (6) | Count at which the clock leaves idle |
| idle_high | input | 1 | Idle level of the clock |
| sclk_off | input | 1 | Holds the output pin at its idle level |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe after the clock leaves idle |
| trail_stb | output | 1 | One-cycle strobe after the clock returns to idle |

## Verification
The bench builds the block with its default widths, a 4-bit prescaler and a 6-bit counter. It sweeps every prescaler setting from 0 to 3 against every N from 0 to 6, each under both idle levels. The expected clock level and both strobes come from the floor/mod formula of R2 and R5, compared cycle by cycle over two full periods. This brings into reach the degenerate N=0 toggle, N=1 with a one-count high phase, the odd and even duty splits, and the restart after each disable. Separate passes cover bypass at both clock phases and the output disable while the strobes keep running.

// File: rtl/spi_sclk_gen.sv
`timescale 1ns/1ps
module spi_sclk_gen #(
  parameter int PRE_W = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bypass,
  input  logic [PRE_W-1:0] pre_div,
  input  logic [CNT_W-1:0] lo_cmp,
  input  logic [CNT_W-1:0] hi_cmp,
  input  logic             idle_high,
  input  logic             sclk_off,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);

  logic [PRE_W-1:0] pcnt;
  logic [CNT_W-1:0] ncnt;
  logic             phase;
  logic             lead_q, trail_q;

  wire run    = en & ~bypass;
  wire tick   = run & (pcnt == pre_div);
  wire at_hi  = (ncnt == hi_cmp);
  wire at_lo  = (ncnt == lo_cmp);
  wire go_act = tick & at_hi & ~at_lo;
  wire go_idl = tick & at_lo & ~at_hi;
  wire flip   = tick & at_hi & at_lo;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pcnt    <= '0;
      ncnt    <= '0;
      phase   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      pcnt    <= tick ? '0 : pcnt + 1'b1;
      if (tick) ncnt <= at_lo ? '0 : ncnt + 1'b1;
      if (go_act)      phase <= 1'b1;
      else if (go_idl) phase <= 1'b0;
      else if (flip)   phase <= ~phase;
      lead_q  <= go_act | (flip & ~phase);
      trail_q <= go_idl | (flip & phase);
    end
  end

  wire pass = en & bypass;

  assign sclk      = sclk_off ? idle_high :
                     pass     ? (clk ^ idle_high) : (phase ^ idle_high);
  assign lead_stb  = pass | lead_q;
  assign trail_stb = pass | trail_q;

endmodule

module spi_sclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic bypass,
  input logic idle_high,
  input logic sclk_off,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb
);
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> !(lead_stb && trail_stb)); // R3
  AST_LEAD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb && !bypass && !sclk_off) |-> (sclk != idle_high)); // R3
  AST_LEAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb && !bypass && !trail_stb) |=> (!lead_stb || bypass)); // R3
  AST_TRAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_stb && !bypass && !sclk_off) |-> (sclk == idle_high)); // R4
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_off |-> (sclk == idle_high)); // R9
  AST_EN_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (!lead_stb && !trail_stb)); // R7
endmodule

bind spi_sclk_gen spi_sclk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bypass(bypass), .idle_high(idle_high),
  .sclk_off(sclk_off), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
);

// File: tb/tb_spi_sclk_gen.sv
`timescale 1ns/1ps
module tb_spi_sclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, bypass = 1'b0, idle_high = 1'b0, sclk_off = 1'b0;
  logic [3:0] pre_div = '0;
  logic [5:0] lo_cmp = '0, hi_cmp = '0;
  logic       sclk, lead_stb, trail_stb;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_sclk_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .bypass(bypass), .pre_div(pre_div),
    .lo_cmp(lo_cmp), .hi_cmp(hi_cmp), .idle_high(idle_high), .sclk_off(sclk_off),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int act_at(input int t, input int p, input int n, input int h);
    int m;
    m = t / (p + 1);
    if (n == 0) return m % 2;
    return ((m % (n + 1)) > h) ? 1 : 0;
  endfunction

  task automatic run_cfg(input int p, input int n, input int idle, input bit off);
    int h;
    h = (n == 0) ? 0 : ((n + 1) / 2 - 1);
    @(negedge clk);
    en = 0; bypass = 0; pre_div = 4'(p); lo_cmp = 6'(n); hi_cmp = 6'(h);
    idle_high = idle[0]; sclk_off = off;
    @(negedge clk);
    en = 1;
    for (int t = 1; t <= 2 * (p + 1) * (n + 1) + 2; t++) begin
      int a, b, es;
      @(negedge clk);
      a = act_at(t, p, n, h);
      b = act_at(t - 1, p, n, h);
      es = off ? idle : (a ^ idle);
      if (off) chk("R9 sclk held", sclk, es);
      else if (n == 0) chk("R5 sclk toggle", sclk, es);
      else if (idle != 0) chk("R6 sclk inverted", sclk, es);
      else chk("R2 sclk level", sclk, es);
      chk("R3 lead_stb", lead_stb, (a == 1 && b == 0) ? 1 : 0);
      chk("R4 trail_stb", trail_stb, (a == 0 && b == 1) ? 1 : 0);
    end
    en = 0;
    @(negedge clk);
    chk("R7 sclk idle after en low", sclk, idle);
    chk("R7 strobes low after en low", {lead_stb, trail_stb}, 0);
    sclk_off = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sclk in reset", sclk, 0);
    chk("R1 strobes in reset", {lead_stb, trail_stb}, 0);
    rst_n = 1;
    @(negedge clk);
    idle_high = 1;
    #0.5;
    chk("R1 sclk idle high, en low", sclk, 1);
    for (int idle = 0; idle < 2; idle++)
      for (int p = 0; p < 4; p++)
        for (int n = 0; n < 7; n++)
          run_cfg(p, n, idle, 1'b0);
    run_cfg(1, 3, 0, 1'b1);
    run_cfg(2, 4, 1, 1'b1);
    for (int idle = 0; idle < 2; idle++) begin
      @(negedge clk);
      bypass = 1; pre_div = 4'd7; lo_cmp = 6'd9; hi_cmp = 6'd4;
      idle_high = idle[0]; en = 1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); #1;
        chk("R8 bypass sclk low phase", sclk, idle);
        chk("R8 bypass strobes", {lead_stb, trail_stb}, 3);
        @(posedge clk); #1;
        chk("R8 bypass sclk high phase", sclk, 1 - idle);
      end
      @(negedge clk);
      en = 0;
      #0.5;
      chk("R8 bypass idle with en low", sclk, idle);
      chk("R8 bypass strobes with en low", {lead_stb, trail_stb}, 0);
      bypass = 0;
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule